// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a single-port synchronous memory. Every address, control and write-data input is sampled on the rising clock edge, and read data leaves through an output register. A transfer opens on either of two start strobes: a processor strobe, which always opens a read, or a controller strobe, which opens a read or a write as the write controls ask. After that, an advance input steps a two-bit burst counter through four words, in either interleaved or linear order. Writes can target any subset of the four byte lanes. A global write control overrides the lane selects and writes the whole word. Three synchronous chip selects decide whether a strobe opens a transfer or parks the block.

The control is a three-state machine. ST_DESEL is the reset state and the parked state. ST_READ means the current cycle reads the burst address, and ST_WRITE means it writes it. A strobe while the chip is selected takes any state to ST_READ or ST_WRITE: the transition is named start_read or start_write. A strobe while the chip is not selected takes any state to ST_DESEL (transition park). With no strobe, ST_READ and ST_WRITE move to each other or stay put by the write controls (transition continue), and ST_DESEL stays where it is (transition idle). The first read after ST_DESEL is flagged, and its data is held off the output. The depth is a parameter. The default is kept small for elaboration, and the full 32K-word depth is reached with ADDR_W = 15.

Top module: `pburst_sram`

## Requirements
- R1: A read in the state register at edge n loads `rdata` at edge n+1, and `rvalid` rises after that edge. A write followed at once by a read of the same word returns the new data.
- R2: A controller strobe (`ctrl_strb_n` low) with the chip selected loads the burst base from `addr` and clears the burst count. The cycle is a write if a write is requested, and a read otherwise.
- R3: A processor strobe (`proc_strb_n` low) with the chip selected always opens a read, and the write controls are ignored in that cycle. It wins over a controller strobe in the same cycle.
- R4: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe without selection enters ST_DESEL, and ST_DESEL gives no `rvalid`.
- R5: With `linear_seq`=0 latched at the start, the two low address bits equal base XOR count.
- R6: With `linear_seq`=1 latched at the start, the two low address bits equal (base + count) mod 4.
- R7: With no strobe, `burst_adv_n`=0 increments the count and `burst_adv_n`=1 holds the address.
- R8: With `all_wr_n`=1 and `byte_wr_en_n`=0, lane i (bits 8i+7..8i) is written when `lane_sel_n[i]`=0. All other lanes keep their contents. With both write controls high, nothing is written.
- R9: `all_wr_n`=0 writes all four lanes, whatever `lane_sel_n` and `byte_wr_en_n` hold.
- R10: The first read that follows ST_DESEL produces no `rvalid`.
- R11: `rvalid` is high only while `out_en_n`=0.
- R12: Reset (`rst_n` low, asynchronous) forces ST_DESEL and clears `rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address sampled with a strobe |
| proc_strb_n | input | 1 | Processor start strobe, active low |
| ctrl_strb_n | input | 1 | Controller start strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| linear_seq | input | 1 | 1 = linear order, 0 = interleaved order, latched at start |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| byte_wr_en_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | DATA_W/8 | Per-lane write select, active low |
| wdata | input | DATA_W | Write data |
| out_en_n | input | 1 | Output enable, active low, not registered |
| rdata | output | DATA_W | Registered read data |
| rvalid | output | 1 | Read data is being presented |

## Verification
The properties assume the strobes and write controls settle before each rising edge. They also assume the output enable is the only input that acts without a clock. The stimulus changes every input on the falling edge and samples outputs there as well. The table writes every word before reading it, so no check ever sees the unknown contents of memory that has not been written. The bursts stay within one aligned four-word block, which the wrap rules require.

// File: rtl/pburst_sram_pkg.sv
package pburst_sram_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_e;

    // Low two address bits for a burst position.
    function automatic logic [1:0] seq_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       lin);
        return lin ? (base + cnt) : (base ^ cnt);
    endfunction

endpackage

// File: rtl/pburst_seq.sv
module pburst_seq
    import pburst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              lin_in,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int CNT_W = 2;

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              lin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b0;
        end else if (load) begin
            base_q <= base_in;
            cnt_q  <= '0;
            lin_q  <= lin_in;
        end else if (step) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign eff_addr = {base_q[ADDR_W-1:CNT_W], seq_low(base_q[CNT_W-1:0], cnt_q, lin_q)};

endmodule

// File: rtl/pburst_fsm.sv
module pburst_fsm
    import pburst_sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             proc_strb,
    input  logic             ctrl_strb,
    input  logic             adv,
    input  logic             chip_sel,
    input  logic [LANES-1:0] req_mask,
    output acc_state_e       state,
    output logic [LANES-1:0] wmask_q,
    output logic             first_q,
    output logic             load,
    output logic             step
);
    acc_state_e       state_nx;
    logic [LANES-1:0] wmask_nx;
    logic             wr_req;

    assign wr_req = |req_mask;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_DESEL;
            wmask_q <= '0;
            first_q <= 1'b0;
        end else begin
            state   <= state_nx;
            wmask_q <= wmask_nx;
            first_q <= (state_nx == ST_READ) && (state == ST_DESEL);
        end
    end

    // Next state and control outputs
    always_comb begin
        state_nx = state;
        wmask_nx = '0;
        load     = 1'b0;
        step     = 1'b0;
        if (proc_strb || ctrl_strb) begin
            if (!chip_sel) begin
                state_nx = ST_DESEL;               // park
            end else begin
                load = 1'b1;
                if (!proc_strb && wr_req) begin    // start_write
                    state_nx = ST_WRITE;
                    wmask_nx = req_mask;
                end else begin                     // start_read
                    state_nx = ST_READ;
                end
            end
        end else begin
            unique case (state)
                ST_DESEL: state_nx = ST_DESEL;     // idle
                ST_READ, ST_WRITE: begin           // continue
                    step = adv;
                    if (wr_req) begin
                        state_nx = ST_WRITE;
                        wmask_nx = req_mask;
                    end else begin
                        state_nx = ST_READ;
                    end
                end
                default: state_nx = ST_DESEL;
            endcase
        end
    end

endmodule

// File: rtl/pburst_array.sv
module pburst_array
    import pburst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  acc_state_e          state,
    input  logic [ADDR_W-1:0]   eff_addr,
    input  logic [DATA_W/8-1:0] wmask,
    input  logic [DATA_W-1:0]   wdata_q,
    input  logic                first_q,
    output logic [DATA_W-1:0]   dout_q,
    output logic                rd_q,
    output logic                hide_q
);
    localparam int LANES = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] bit_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_en[8*g +: 8] = {8{wmask[g]}};
    end

    always_ff @(posedge clk) begin
        if (state == ST_WRITE)
            mem[eff_addr] <= (mem[eff_addr] & ~bit_en) | (wdata_q & bit_en);
        if (state == ST_READ)
            dout_q <= mem[eff_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            hide_q <= 1'b0;
        end else begin
            rd_q   <= (state == ST_READ);
            hide_q <= first_q;
        end
    end

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
    import pburst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                proc_strb_n,
    input  logic                ctrl_strb_n,
    input  logic                burst_adv_n,
    input  logic                linear_seq,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                all_wr_n,
    input  logic                byte_wr_en_n,
    input  logic [DATA_W/8-1:0] lane_sel_n,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                out_en_n,
    output logic [DATA_W-1:0]   rdata,
    output logic                rvalid
);
    localparam int LANES = DATA_W / 8;

    acc_state_e        state;
    logic [LANES-1:0]  req_mask;
    logic [LANES-1:0]  wmask_q;
    logic              first_q;
    logic              load;
    logic              step;
    logic              chip_sel;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] wdata_q;
    logic              rd_q;
    logic              hide_q;

    assign chip_sel = !sel_a_n && sel_b && !sel_c_n;
    assign req_mask = !all_wr_n     ? {LANES{1'b1}} :
                      !byte_wr_en_n ? ~lane_sel_n   : {LANES{1'b0}};

    always_ff @(posedge clk) wdata_q <= wdata;

    pburst_fsm #(.LANES(LANES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .proc_strb(!proc_strb_n), .ctrl_strb(!ctrl_strb_n),
        .adv(!burst_adv_n), .chip_sel(chip_sel), .req_mask(req_mask),
        .state(state), .wmask_q(wmask_q), .first_q(first_q),
        .load(load), .step(step)
    );

    pburst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .base_in(addr), .lin_in(linear_seq), .eff_addr(eff_addr)
    );

    pburst_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .state(state), .eff_addr(eff_addr),
        .wmask(wmask_q), .wdata_q(wdata_q), .first_q(first_q),
        .dout_q(rdata), .rd_q(rd_q), .hide_q(hide_q)
    );

    assign rvalid = rd_q && !hide_q && !out_en_n;

endmodule

// File: rtl/pburst_sram_chk.sv
module pburst_sram_chk
    import pburst_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_strb_n,
    input logic              ctrl_strb_n,
    input logic              burst_adv_n,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              all_wr_n,
    input logic              rvalid,
    input acc_state_e        state,
    input logic [LANES-1:0]  wmask_q,
    input logic [ADDR_W-1:0] eff_addr
);
    logic sel_ok;
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    p_park_unselected_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((!proc_strb_n || !ctrl_strb_n) && !sel_ok) |=> (state == ST_DESEL));

    p_proc_opens_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strb_n && sel_ok) |=> (state == ST_READ));

    p_global_write_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strb_n && !ctrl_strb_n && sel_ok && !all_wr_n)
        |=> (state == ST_WRITE && wmask_q == {LANES{1'b1}}));

    p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strb_n && ctrl_strb_n && burst_adv_n && state != ST_DESEL)
        |=> $stable(eff_addr));

    p_first_read_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state) == ST_DESEL) |=> !rvalid);

    p_valid_after_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> ($past(state) == ST_READ));

endmodule

bind pburst_sram pburst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .proc_strb_n(proc_strb_n),
    .ctrl_strb_n(ctrl_strb_n), .burst_adv_n(burst_adv_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .all_wr_n(all_wr_n), .rvalid(rvalid), .state(state),
    .wmask_q(wmask_q), .eff_addr(eff_addr)
);

// File: tb/tb_pburst_sram.sv
module tb_pburst_sram;
    localparam int AW = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          proc_strb_n = 1'b1, ctrl_strb_n = 1'b1, burst_adv_n = 1'b1;
    logic          linear_seq = 1'b0;
    logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic          all_wr_n = 1'b1, byte_wr_en_n = 1'b1;
    logic [3:0]    lane_sel_n = 4'hF;
    logic [DW-1:0] wdata = '0;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pburst_sram #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

    // strb: 0 none, 1 processor, 2 controller. ev/ed: output expected after the step.
    typedef struct packed {
        logic [1:0]  strb;
        logic        sel;
        logic        adv;
        logic        gw_n;
        logic        bwe_n;
        logic [3:0]  bw_n;
        logic        lin;
        logic        oe_n;
        logic [9:0]  a;
        logic [31:0] wd;
        logic        ev;
        logic [31:0] ed;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{2'd2,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,10'h010,32'hA0A00000,1'b0,32'h0,4'd2},        // R2 write start
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,1'b0,10'h000,32'hA0A00001,1'b0,32'h0,4'd9},        // R9
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,1'b0,10'h000,32'hA0A00002,1'b0,32'h0,4'd9},
        '{2'd0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,1'b0,10'h000,32'hA0A00003,1'b0,32'h0,4'd9},
        '{2'd1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,10'h012,32'h0,1'b0,32'h0,4'd3},               // R3 read start
        '{2'd0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,1'b0,10'h000,32'h0,1'b1,32'hA0A00002,4'd1},        // R1 latency
        '{2'd0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,1'b0,10'h000,32'h0,1'b1,32'hA0A00003,4'd5},        // R5 2^1
        '{2'd0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,1'b0,10'h000,32'h0,1'b1,32'hA0A00000,4'd5},        // R5 2^2
        '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,10'h000,32'h0,1'b1,32'hA0A00001,4'd5},        // R5 2^3
        '{2'd2,1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,10'h000,32'h0,1'b1,32'hA0A00001,4'd7},        // R7 hold
        '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,10'h000,32'h0,1'b0,32'h0,4'd4},               // R4 parked
        '{2'd2,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,10'h011,32'h0,1'b0,32'h0,4'd4},
        '{2'd0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,10'h000,32'h0,1'b0,32'h0,4'd10},              // R10 hidden
        '{2'd0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,10'h000,32'h0,1'b1,32'hA0A00002,4'd6},        // R6 1+1
        '{2'd0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,10'h000,32'h0,1'b1,32'hA0A00003,4'd6},        // R6 1+2
        '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b1,10'h000,32'h0,1'b0,32'h0,4'd11},              // R11 oe off
        '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,10'h000,32'h0,1'b1,32'hA0A00000,4'd7},        // R7, R6 wrap
        '{2'd2,1'b1,1'b0,1'b1,1'b0,4'hA,1'b0,1'b0,10'h012,32'h11223344,1'b1,32'hA0A00000,4'd11},// R8 lanes 0,2
        '{2'd1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,10'h012,32'hFFFFFFFF,1'b0,32'h0,4'd8},
        '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,10'h000,32'h0,1'b1,32'hA0220044,4'd8},        // R8, R3 ignored write
        '{2'd2,1'b1,1'b0,1'b0,1'b0,4'hF,1'b0,1'b0,10'h030,32'h12345678,1'b1,32'hA0220044,4'd1},
        '{2'd2,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,10'h030,32'h0,1'b0,32'h0,4'd9},
        '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,10'h000,32'h0,1'b1,32'h12345678,4'd9},        // R9 override, R1
        '{2'd2,1'b1,1'b0,1'b1,1'b1,4'h0,1'b0,1'b0,10'h030,32'h0,1'b1,32'h12345678,4'd8},
        '{2'd0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,10'h000,32'h0,1'b1,32'h12345678,4'd8}         // R8 no write
    };

    task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rvalid == 1'b0, 12, {31'd0, rvalid}, 32'd0);       // R12 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            proc_strb_n  = !(VEC[i].strb == 2'd1);
            ctrl_strb_n  = !(VEC[i].strb == 2'd2);
            sel_b        = VEC[i].sel;
            burst_adv_n  = !VEC[i].adv;
            all_wr_n     = VEC[i].gw_n;
            byte_wr_en_n = VEC[i].bwe_n;
            lane_sel_n   = VEC[i].bw_n;
            linear_seq   = VEC[i].lin;
            out_en_n     = VEC[i].oe_n;
            addr         = VEC[i].a;
            wdata        = VEC[i].wd;
            @(posedge clk);
            @(negedge clk);
            check(rvalid == VEC[i].ev, int'(VEC[i].rq), {31'd0, rvalid}, {31'd0, VEC[i].ev});
            if (VEC[i].ev)
                check(rdata == VEC[i].ed, int'(VEC[i].rq), rdata, VEC[i].ed);
        end

        // R12: reset during a running read clears the output and parks the block
        proc_strb_n = 1'b1; ctrl_strb_n = 1'b0; all_wr_n = 1'b1; byte_wr_en_n = 1'b1;
        sel_b = 1'b1; out_en_n = 1'b0; addr = 10'h030;
        @(posedge clk); @(negedge clk);
        ctrl_strb_n = 1'b1; burst_adv_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(rvalid == 1'b1 && rdata == 32'h12345678, 1, rdata, 32'h12345678); // R1
        rst_n = 1'b0;
        #1;
        check(rvalid == 1'b0, 12, {31'd0, rvalid}, 32'd0);       // R12
        @(negedge clk);
        rst_n = 1'b1;
        burst_adv_n = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check(rvalid == 1'b0, 12, {31'd0, rvalid}, 32'd0);       // R12 no burst after reset

        // R4: one select wrong at a time parks the block
        sel_a_n = 1'b1; ctrl_strb_n = 1'b0; burst_adv_n = 1'b1;
        @(posedge clk); @(negedge clk);
        sel_a_n = 1'b0; ctrl_strb_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(rvalid == 1'b0, 4, {31'd0, rvalid}, 32'd0);        // R4
        sel_c_n = 1'b1; proc_strb_n = 1'b0;
        @(posedge clk); @(negedge clk);
        sel_c_n = 1'b0; proc_strb_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(rvalid == 1'b0, 4, {31'd0, rvalid}, 32'd0);        // R4

        finish_run();
    end

endmodule